// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a serial master for SPI-style slaves. Software programs a control word and a prescaler, writes frames into an 8-entry transmit queue, and collects the frames that come back from an 8-entry receive queue. The block drives the serial clock and the serial output, and it samples the serial input. It raises a frame indication while a frame is on the wire. Chip select lies outside the block and software drives it.

The bit rate is the system clock divided by the product of an even prescaler and (rate field + 1). Each frame that shifts out also captures one frame from the input line. A transfer that only writes therefore still fills the receive queue, and software has to drain it. A loopback bit routes the serial output back to the serial input internally.

The register port is a single-cycle bus. Reads are combinational, and a read of the data word pops the receive queue at the clock edge. The word index selects the register: 0 is control, 1 is prescaler, 2 is data and 3 is status. The control word holds the frame size minus one in bits [3:0], clock polarity in bit 4, clock phase in bit 5, loopback in bit 6, enable in bit 7 and the rate field in bits [15:8]. The status word holds transmit-empty in bit 0, transmit-not-full in bit 1, receive-not-empty in bit 2, receive-full in bit 3 and busy in bit 4.

Top module: `ssp_master`

## Requirements
- R1: After reset, control reads 0x0007 (8-bit frames, mode 0, disabled), prescaler reads 2, status reads 0x0003, and the serial clock and frame outputs are low.
- R2: A prescaler write below 2 stores 2. An odd write stores the next even value, and 255 stores 254. An even write from 2 to 254 is stored unchanged.
- R3: During a frame, consecutive serial clock transitions are spaced by prescaler/2 × (rate + 1) system clock cycles.
- R4: A frame carries (size field + 1) bits, most significant bit first, over exactly twice that many serial clock transitions. The frame output is high while the frame runs.
- R5: When no frame is running, the serial clock rests at the polarity bit. With phase 0 the data is valid on the leading transition; with phase 1 it is valid on the trailing transition. Modes 0 to 3 map to (polarity, phase) = (0,0), (0,1), (1,0), (1,1).
- R6: With loopback set, the received frame equals the transmitted frame masked to the frame size. With loopback clear, the frame is taken from the serial input pin.
- R7: Every completed frame pushes one received word. Words read back in arrival order, and a read from an empty receive queue returns 0.
- R8: The transmit queue holds 8 words, and a write to a full queue is dropped.
- R9: Busy stays set after transmit-empty rises while the last frame is still shifting, and it clears once the frame ends.
- R10: No frame starts while enable is clear. Clearing enable mid-frame aborts the frame: the serial clock returns to idle, the frame output falls, and no word is received.
- R11: A frame that completes while the receive queue is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| frame_o | output | 1 | High while a frame is shifting |

## Verification
The assertions assume that the frame size, polarity, phase, rate and prescaler are held constant while a frame runs. Only the enable bit may change mid-frame. The stimulus respects this: it changes configuration only after polling the status word until busy is clear, and the abort scenario touches nothing but the enable bit during a frame. A monitor samples the serial output on the edge that the configured phase selects, counts the clock transitions and checks their spacing against the programmed divider.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 16;
  localparam int PW = 8;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_PRESC = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  typedef struct packed {
    logic [7:0] rate;
    logic       en;
    logic       loop;
    logic       cpha;
    logic       cpol;
    logic [3:0] fsize;
  } ssp_ctrl_t;

  function automatic logic [PW-1:0] legal_presc(input logic [PW-1:0] v);
    if (v < PW'(2))               return PW'(2);
    else if (v == {PW{1'b1}})     return {{(PW-1){1'b1}}, 1'b0};
    else if (v[0])                return v + PW'(1);
    else                          return v;
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr)));

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_ptr)));
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] presc_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o
);
  localparam int CW = PW + RW;

  logic [CW-1:0] half, cnt;

  // half serial period = (presc/2) * (rate+1)
  assign half   = CW'(presc_i[PW-1:1]) * (CW'(rate_i) + CW'(1));
  assign tick_o = run_i && (cnt == half - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || tick_o)  cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half != CW'(1) && run_i) |=> !tick_o);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   cpol_i,
  input  logic                   cpha_i,
  input  logic [$clog2(DW)-1:0]  fsize_i,
  input  logic                   miso_i,
  input  logic                   tick_i,
  input  logic                   tx_valid_i,
  input  logic [DW-1:0]          tx_data_i,
  output logic                   tx_pop_o,
  output logic                   rx_push_o,
  output logic [DW-1:0]          rx_data_o,
  output logic                   active_o,
  output logic                   sclk_o,
  output logic                   mosi_o
);
  localparam int BW = $clog2(DW);

  logic          active, lvl;
  logic [BW:0]   edge_cnt;
  logic [DW-1:0] tx_sr, rx_sr, rx_next, mask;
  logic [BW:0]   nbits;
  logic          leading, last_edge, samp, shift_out;

  assign leading   = !lvl;
  assign last_edge = (edge_cnt == {fsize_i, 1'b1});
  assign samp      = cpha_i ? !leading : leading;
  assign shift_out = cpha_i ? (leading && edge_cnt != '0) : (!leading && !last_edge);
  assign rx_next   = samp ? {rx_sr[DW-2:0], miso_i} : rx_sr;
  assign nbits     = {1'b0, fsize_i} + (BW+1)'(1);
  assign mask      = ~({DW{1'b1}} << nbits);

  assign tx_pop_o  = !active && en_i && tx_valid_i;
  assign rx_push_o = active && en_i && tick_i && last_edge;
  assign rx_data_o = rx_next & mask;
  assign active_o  = active;
  assign sclk_o    = cpol_i ^ lvl;
  assign mosi_o    = tx_sr[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active   <= 1'b0;
      lvl      <= 1'b0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else if (!en_i) begin
      active   <= 1'b0;
      lvl      <= 1'b0;
    end else if (tx_pop_o) begin
      active   <= 1'b1;
      lvl      <= 1'b0;
      edge_cnt <= '0;
      tx_sr    <= tx_data_i << (BW'(DW-1) - fsize_i);
      rx_sr    <= '0;
    end else if (active && tick_i) begin
      lvl      <= !lvl;
      edge_cnt <= edge_cnt + (BW+1)'(1);
      rx_sr    <= rx_next;
      if (shift_out) tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (last_edge) begin
        active <= 1'b0;
        lvl    <= 1'b0;
      end
    end
  end

  // R5
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (sclk_o == cpol_i));

  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!active_o && !rx_push_o));

  // R4
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i && en_i) |=> $stable(mosi_o));

  // R4
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> !active_o);
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          frame_o
);
  ssp_ctrl_t     ctrl_q;
  logic [PW-1:0] presc_q;

  logic          tx_push, tx_pop, tx_empty, tx_full;
  logic [DW-1:0] tx_head;
  logic          rx_push, rx_pop, rx_empty, rx_full;
  logic [DW-1:0] rx_head, rx_word;
  logic          active, tick, busy, miso_int;
  logic [DW-1:0] status;

  logic wr_en, rd_en;
  assign wr_en   = bus_sel_i && bus_we_i;
  assign rd_en   = bus_sel_i && !bus_we_i;
  assign tx_push = wr_en && (bus_addr_i == ADDR_DATA);
  assign rx_pop  = rd_en && (bus_addr_i == ADDR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{rate: '0, en: 1'b0, loop: 1'b0, cpha: 1'b0, cpol: 1'b0, fsize: 4'd7};
      presc_q <= PW'(2);
    end else if (wr_en) begin
      if (bus_addr_i == ADDR_CTRL)  ctrl_q  <= ssp_ctrl_t'(bus_wdata_i);
      if (bus_addr_i == ADDR_PRESC) presc_q <= legal_presc(bus_wdata_i[PW-1:0]);
    end
  end

  assign busy   = active || (ctrl_q.en && !tx_empty);
  assign status = {{(DW-5){1'b0}}, busy, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    case (bus_addr_i)
      ADDR_CTRL:  bus_rdata_o = DW'(ctrl_q);
      ADDR_PRESC: bus_rdata_o = DW'(presc_q);
      ADDR_DATA:  bus_rdata_o = rx_empty ? '0 : rx_head;
      default:    bus_rdata_o = status;
    endcase
  end

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(bus_wdata_i),
    .pop_i(tx_pop),   .data_o(tx_head),
    .empty_o(tx_empty), .full_o(tx_full)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_word),
    .pop_i(rx_pop),   .data_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full)
  );

  ssp_clkgen #(.PW(PW), .RW(8)) u_clk (
    .clk_i, .rst_ni,
    .run_i(active), .presc_i(presc_q), .rate_i(ctrl_q.rate),
    .tick_o(tick)
  );

  assign miso_int = ctrl_q.loop ? mosi_o : miso_i;

  ssp_shifter #(.DW(DW)) u_shf (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.en), .cpol_i(ctrl_q.cpol), .cpha_i(ctrl_q.cpha),
    .fsize_i(ctrl_q.fsize), .miso_i(miso_int), .tick_i(tick),
    .tx_valid_i(!tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_word), .active_o(active),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  assign frame_o = active;

  // R2
  presc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!presc_q[0] && presc_q >= PW'(2)));

  // R9
  busy_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> status[4]);

  // R10
  no_start_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !frame_o) |=> !frame_o);
endmodule

// File: tb/ssp_master_test.sv
module ssp_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi, frame;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ssp_master uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .frame_o(frame)
  );

  // monitor state
  int          presc_b = 2, exp_half = 1;
  logic        cpol_b = 0, cpha_b = 0;
  int          edges = 0, since = 0;
  logic        seen = 0, iv_bad = 0, prev_sclk = 0, prev_frame = 0;
  logic [15:0] cap = '0;

  always @(negedge clk) begin
    since = since + 1;
    if (frame && !prev_frame) seen = 0;
    if (sclk !== prev_sclk) begin
      edges = edges + 1;
      if (seen && since != exp_half) iv_bad = 1;
      seen  = 1;
      since = 0;
      if (cpha_b ? (sclk == cpol_b) : (sclk != cpol_b)) cap = {cap[14:0], mosi};
    end
    prev_sclk  = sclk;
    prev_frame = frame;
  end

  task automatic mon_clear();
    @(negedge clk);
    #1;
    edges = 0; cap = '0; iv_bad = 0; seen = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic set_presc(input int p);
    bus_wr(2'd1, 16'(p));
    presc_b = p;
  endtask

  task automatic cfg(input int fs, input bit cp, input bit ph, input bit lb,
                     input bit en, input int rate);
    bus_wr(2'd0, 16'((rate << 8) | (en << 7) | (lb << 6) | (ph << 5) | (cp << 4) | fs));
    cpol_b = cp; cpha_b = ph;
    exp_half = (presc_b / 2) * (rate + 1);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(2'd3, s);
      if (!s[4]) return;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_rd(2'd0, v); check("R1 ctrl", v, 16'h0007);
    bus_rd(2'd1, v); check("R1 presc", v, 2);
    bus_rd(2'd3, v); check("R1 status", v, 16'h0003);
    check("R1 sclk", sclk, 0);
    check("R1 frame", frame, 0);
  endtask

  task automatic t_presc();
    logic [15:0] v;
    bus_wr(2'd1, 16'd0);   bus_rd(2'd1, v); check("R2 presc 0", v, 2);
    bus_wr(2'd1, 16'd1);   bus_rd(2'd1, v); check("R2 presc 1", v, 2);
    bus_wr(2'd1, 16'd5);   bus_rd(2'd1, v); check("R2 presc 5", v, 6);
    bus_wr(2'd1, 16'd255); bus_rd(2'd1, v); check("R2 presc 255", v, 254);
    bus_wr(2'd1, 16'd100); bus_rd(2'd1, v); check("R2 presc 100", v, 100);
  endtask

  task automatic t_mode(input int mode, input logic [7:0] d, input int p, input int rate);
    logic [15:0] v;
    set_presc(p);
    cfg(7, mode[1], mode[0], 1, 1, rate);
    repeat (2) @(negedge clk);
    check($sformatf("R5 idle level mode %0d", mode), sclk, mode[1]);
    mon_clear();
    bus_wr(2'd2, {8'h00, d});
    wait_idle();
    check($sformatf("R4 edges mode %0d", mode), edges, 16);
    check($sformatf("R5 sampled bits mode %0d", mode), cap[7:0], d);
    check($sformatf("R3 spacing mode %0d", mode), iv_bad, 0);
    check($sformatf("R5 rest after mode %0d", mode), sclk, mode[1]);
    bus_rd(2'd2, v);
    check($sformatf("R6 loopback mode %0d", mode), v, d);
    bus_rd(2'd3, v);
    check("R7 rx drained", v[2], 0);
  endtask

  task automatic t_size();
    logic [15:0] v;
    set_presc(2);
    cfg(11, 0, 0, 1, 1, 0);
    mon_clear();
    bus_wr(2'd2, 16'hF3C5);
    wait_idle();
    check("R4 12-bit edges", edges, 24);
    check("R4 12-bit msb first", cap[11:0], 12'h3C5);
    bus_rd(2'd2, v); check("R4 12-bit rx", v, 16'h03C5);
    cfg(3, 0, 1, 1, 1, 0);
    mon_clear();
    bus_wr(2'd2, 16'h007B);
    wait_idle();
    check("R4 4-bit edges", edges, 8);
    bus_rd(2'd2, v); check("R4 4-bit rx", v, 16'h000B);
    cfg(15, 1, 1, 1, 1, 0);
    mon_clear();
    bus_wr(2'd2, 16'h8E71);
    wait_idle();
    check("R4 16-bit edges", edges, 32);
    bus_rd(2'd2, v); check("R4 16-bit rx", v, 16'h8E71);
  endtask

  task automatic t_miso();
    logic [15:0] v;
    set_presc(2);
    cfg(7, 0, 0, 0, 1, 0);
    miso = 1;
    bus_wr(2'd2, 16'h0000);
    wait_idle();
    bus_rd(2'd2, v); check("R6 pin input high", v, 16'h00FF);
    miso = 0;
    mon_clear();
    bus_wr(2'd2, 16'h00FF);
    wait_idle();
    check("R6 output unaffected", cap[7:0], 8'hFF);
    bus_rd(2'd2, v); check("R6 pin input low", v, 16'h0000);
  endtask

  task automatic t_drain();
    logic [15:0] v;
    cfg(7, 0, 1, 1, 1, 1);
    bus_wr(2'd2, 16'h0011);
    bus_wr(2'd2, 16'h0022);
    bus_wr(2'd2, 16'h0033);
    wait_idle();
    bus_rd(2'd2, v); check("R7 first", v, 16'h11);
    bus_rd(2'd2, v); check("R7 second", v, 16'h22);
    bus_rd(2'd2, v); check("R7 third", v, 16'h33);
    bus_rd(2'd2, v); check("R7 empty read", v, 0);
  endtask

  task automatic t_tx_full();
    logic [15:0] v;
    cfg(7, 0, 0, 1, 0, 0);
    for (int i = 0; i < 9; i++) bus_wr(2'd2, 16'(8'h40 + i));
    bus_rd(2'd3, v);
    check("R8 tx full flag", v[1:0], 2'b00);
    check("R10 no frame while disabled", frame, 0);
    check("R10 nothing received", v[2], 0);
    cfg(7, 0, 0, 1, 1, 0);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      bus_rd(2'd2, v);
      check("R8 queued word", v, 8'h40 + i);
    end
    bus_rd(2'd2, v); check("R8 ninth dropped", v, 0);
  endtask

  task automatic t_rx_full();
    logic [15:0] v;
    cfg(7, 0, 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) bus_wr(2'd2, 16'(8'h60 + i));
    wait_idle();
    bus_rd(2'd3, v); check("R11 rx full flag", v[3], 1);
    bus_wr(2'd2, 16'h00EE);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      bus_rd(2'd2, v);
      check("R11 kept word", v, 8'h60 + i);
    end
    bus_rd(2'd2, v); check("R11 overflow frame discarded", v, 0);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    set_presc(2);
    cfg(7, 0, 0, 1, 1, 7);
    bus_wr(2'd2, 16'h005A);
    v = '0;
    for (int i = 0; i < 200 && !v[0]; i++) bus_rd(2'd3, v);
    check("R9 tx empty seen", v[0], 1);
    check("R9 busy after tx empty", v[4], 1);
    check("R4 frame high while shifting", frame, 1);
    wait_idle();
    bus_rd(2'd3, v); check("R9 busy cleared", v[4], 0);
    bus_rd(2'd2, v); check("R9 data", v, 16'h5A);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    set_presc(4);
    cfg(7, 1, 0, 1, 1, 3);
    bus_wr(2'd2, 16'h00C3);
    repeat (40) @(negedge clk);
    check("R10 mid frame", frame, 1);
    cfg(7, 1, 0, 1, 0, 3);
    repeat (2) @(negedge clk);
    check("R10 frame dropped", frame, 0);
    check("R10 sclk idle", sclk, 1);
    bus_rd(2'd3, v);
    check("R10 not busy", v[4], 0);
    check("R10 no rx word", v[2], 0);
    cfg(7, 1, 0, 1, 1, 3);
    repeat (20) @(negedge clk);
    check("R10 no restart", frame, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_presc();
    t_mode(0, 8'hA5, 2, 0);
    t_mode(1, 8'h3C, 4, 1);
    t_mode(2, 8'h81, 6, 2);
    t_mode(3, 8'h5E, 2, 4);
    t_size();
    t_miso();
    t_drain();
    t_tx_full();
    t_rx_full();
    t_busy();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule